// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns a single transfer request into one complete processor-style bus cycle on a narrow shared bus. The bus has three parts. The low byte carries the address first and then data. The middle address byte stays steady for the whole cycle. The four upper lines show the top address bits first and then a status nibble. A request names one of seven cycle kinds: code fetch, memory read, memory write, I/O read, I/O write, interrupt acknowledge and halt. It also carries a 20-bit address, a 2-bit segment tag and a write byte.

The sequencer runs on a clock at twice the bus-state rate. A phase bit splits every bus state (T1, T2, T3, optional waits, T4) into a first and a second half, so strobes can change in the middle of a state. Tri-state pads are modelled as an output enable on the low byte.

A requester presents work with a valid level and sees an accept pulse. It can chain a new request in the last half of T4, so cycles run back to back. Read data is captured on the last half-state before T4 and is held on `rd_data`.

Top module: `mux_bus_sequencer`

## Requirements
- R1: After reset the block is idle: `ale` low, `rd_n`/`wr_n`/`inta_n`/`den_n` high, status triple {`io_m`,`dt_r`,`ss0`} = 011, `cyc_done` and `req_accept` low, `a_hi` zero, `ad_oe` low.
- R2: A request is accepted (one-tick `req_accept`) only while idle or in the second half of T4. Kind 011 is never accepted. A request seen at any other time, or of kind 011, starts no cycle and changes neither outputs nor the held address.
- R3: Each bus state lasts two ticks. `ale` is high for exactly the two ticks of T1. A cycle with no waits spans eight ticks from T1 to the end of T4. `cyc_done` is high for one tick, the second half of T4.
- R4: `ready` is sampled on the second half of T3 and of each wait state. Low inserts one two-tick wait state; high moves to T4.
- R5: `rd_n` is driven for kinds 000, 001 and 101. `wr_n` is driven for kinds 010 and 110. `inta_n` is driven for kind 100. The strobe is low from T2 through the last wait and high otherwise. Halt (111) drives no strobe.
- R6: `den_n` is low for reads and acknowledges from the second half of T2 to the first half of T4. For writes it is low from the first half of T2 to the first half of T4. It stays high for halt.
- R7: During T1 to T4 the status triple equals the request kind: 000 code, 001 mem read, 010 mem write, 100 acknowledge, 101 I/O read, 110 I/O write, 111 halt. In idle it is 011.
- R8: `a_hi` shows address bits 19..16 in T1, or zero when kind bit 2 is 1. From T2 to T4 it shows {0, `ie_flag`, segment tag}. The tag codes are 00 alternate, 01 stack, 10 code/none, 11 data. `a_hi` is zero in idle.
- R9: `a_mid` shows address bits 15..8 from T1 through T4. It keeps that value in idle until the next accepted cycle.
- R10: `ad_oe` is high in T1 with address bits 7..0 on `ad_out`. For writes it stays high from T2 to T4 with the write byte. For other kinds it is low from T2. For kinds 000, 001, 101 and 100, `ad_in` is captured at the second half of the final T3/wait and is shown on `rd_data` from T4.
- R11: A request accepted in the second half of T4 starts T1 on the next tick, with no idle tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, two ticks per bus state |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind, same code as the status triple |
| req_addr | input | 20 | Byte address |
| req_seg | input | 2 | Segment tag shown in status |
| req_wdata | input | 8 | Write byte |
| ie_flag | input | 1 | Interrupt-enable flag reflected on status |
| ready | input | 1 | Target ready, low inserts waits |
| ad_in | input | 8 | Low-byte bus input for reads |
| req_accept | output | 1 | Request taken this tick |
| cyc_done | output | 1 | Second half of T4 |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Acknowledge strobe, active low |
| den_n | output | 1 | Data transceiver enable, active low |
| io_m | output | 1 | Status bit 2 |
| dt_r | output | 1 | Status bit 1 |
| ss0 | output | 1 | Status bit 0 |
| ad_out | output | 8 | Low-byte bus output |
| ad_oe | output | 1 | Low-byte drive enable |
| a_mid | output | 8 | Address bits 15..8 |
| a_hi | output | 4 | Upper address or status nibble |
| rd_data | output | 8 | Captured read byte |

## Verification
The assertions assume that `ready` is a clean level sampled only on the edge that ends a second half-state. They also assume that request fields hold steady during the tick that `req_valid` is high. The bench changes every input one time unit after a rising edge. It presents a request only as a single-tick level. It drives `ready` low only for the planned number of waits, so each assumption holds. The stimulus also sends requests at times the block must ignore, and a request of kind 011, to exercise the acceptance window without breaking these assumptions.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    parameter int ADDR_W = 20;
    parameter int LO_W   = 8;
    parameter int MID_W  = 8;
    localparam int HI_W   = ADDR_W - LO_W - MID_W;
    localparam int SEG_W  = 2;
    localparam int KIND_W = 3;

    // kind code equals the {io_m, dt_r, ss0} status triple
    typedef enum logic [KIND_W-1:0] {
        K_CODE = 3'b000,
        K_MRD  = 3'b001,
        K_MWR  = 3'b010,
        K_NONE = 3'b011,
        K_ACK  = 3'b100,
        K_IORD = 3'b101,
        K_IOWR = 3'b110,
        K_HALT = 3'b111
    } kind_e;

    typedef enum logic [2:0] {
        TS_I, TS_1, TS_2, TS_3, TS_W, TS_4
    } tstate_e;

    typedef struct packed {
        kind_e               kind;
        logic [ADDR_W-1:0]   addr;
        logic [SEG_W-1:0]    seg;
        logic [LO_W-1:0]     wdata;
    } req_t;

    function automatic logic kind_reads(kind_e k);
        return (k == K_CODE) || (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic kind_writes(kind_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    function automatic logic kind_takes_data(kind_e k);
        return kind_reads(k) || (k == K_ACK);
    endfunction

    function automatic logic kind_hi_blank(kind_e k);
        logic [KIND_W-1:0] c;
        c = k;
        return c[KIND_W-1];
    endfunction
endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
    import mbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  kind_e   req_kind,
    input  logic    ready,
    output tstate_e state,
    output logic    ph,
    output logic    accept,
    output logic    done,
    output logic    capture
);
    logic window;

    always_comb begin
        window  = (state == TS_I) || ((state == TS_4) && ph);
        accept  = req_valid && (req_kind != K_NONE) && window;
        done    = (state == TS_4) && ph;
        capture = ((state == TS_3) || (state == TS_W)) && ph && ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TS_I;
            ph    <= 1'b0;
        end else if (state == TS_I) begin
            ph <= 1'b0;
            if (accept) state <= TS_1;
        end else begin
            ph <= ~ph;
            if (ph) begin
                case (state)
                    TS_1:       state <= TS_2;
                    TS_2:       state <= TS_3;
                    TS_3, TS_W: state <= ready ? TS_4 : TS_W;
                    TS_4:       state <= accept ? TS_1 : TS_I;
                    default:    state <= TS_I;
                endcase
            end
        end
    end

    p_t1_half_r3: assert property (@(posedge clk) disable iff (rst)
        (state == TS_1 && !ph) |=> (state == TS_1 && ph));
    p_wait_insert_r4: assert property (@(posedge clk) disable iff (rst)
        ((state == TS_3 || state == TS_W) && ph && !ready) |=> (state == TS_W && !ph));
    p_accept_window_r2: assert property (@(posedge clk) disable iff (rst)
        accept |-> (state == TS_I || (state == TS_4 && ph)));
    p_chain_r11: assert property (@(posedge clk) disable iff (rst)
        (done && accept) |=> (state == TS_1 && !ph));
endmodule

// File: rtl/mbs_hold.sv
module mbs_hold
    import mbs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  req_t            req_in,
    input  logic            capture,
    input  logic [LO_W-1:0] ad_in,
    output req_t            req_q,
    output logic [LO_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            rd_data <= '0;
        end else begin
            if (accept) req_q <= req_in;
            if (capture && kind_takes_data(req_q.kind)) rd_data <= ad_in;
        end
    end

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(req_q.addr));
endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
    import mbs_pkg::*;
(
    input  tstate_e          state,
    input  logic             ph,
    input  req_t             req_q,
    input  logic             ie_flag,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             inta_n,
    output logic             den_n,
    output logic [2:0]       status,
    output logic [LO_W-1:0]  ad_out,
    output logic             ad_oe,
    output logic [MID_W-1:0] a_mid,
    output logic [HI_W-1:0]  a_hi
);
    logic strobe_win, den_rd_win, den_wr_win, active;

    always_comb begin
        active     = (state != TS_I);
        strobe_win = (state == TS_2) || (state == TS_3) || (state == TS_W);
        den_wr_win = strobe_win || ((state == TS_4) && !ph);
        den_rd_win = ((state == TS_2) && ph) || (state == TS_3) ||
                     (state == TS_W) || ((state == TS_4) && !ph);

        ale    = (state == TS_1);
        rd_n   = !(strobe_win && kind_reads(req_q.kind));
        wr_n   = !(strobe_win && kind_writes(req_q.kind));
        inta_n = !(strobe_win && (req_q.kind == K_ACK));

        if (kind_writes(req_q.kind))          den_n = !den_wr_win;
        else if (kind_takes_data(req_q.kind)) den_n = !den_rd_win;
        else                                  den_n = 1'b1;

        status = active ? req_q.kind : K_NONE;

        ad_oe  = (state == TS_1) || (active && kind_writes(req_q.kind));
        ad_out = (state == TS_1) ? req_q.addr[LO_W-1:0] : req_q.wdata;
        a_mid  = req_q.addr[LO_W +: MID_W];

        case (state)
            TS_I:    a_hi = '0;
            TS_1:    a_hi = kind_hi_blank(req_q.kind) ? '0 : req_q.addr[ADDR_W-1 -: HI_W];
            default: a_hi = HI_W'({ie_flag, req_q.seg});
        endcase
    end

    always_comb begin
        p_strobe_excl_r5: assert ($onehot0({~rd_n, ~wr_n, ~inta_n}));
        p_ale_quiet_r5:   assert (!ale || (rd_n && wr_n && inta_n));
        p_den_halt_r6:    assert (status != 3'b111 || den_n);
        p_idle_pass_r7:   assert (active || status == 3'b011);
    end
endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
    import mbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [LO_W-1:0]  req_wdata,
    input  logic             ie_flag,
    input  logic             ready,
    input  logic [LO_W-1:0]  ad_in,
    output logic             req_accept,
    output logic             cyc_done,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             inta_n,
    output logic             den_n,
    output logic             io_m,
    output logic             dt_r,
    output logic             ss0,
    output logic [LO_W-1:0]  ad_out,
    output logic             ad_oe,
    output logic [MID_W-1:0] a_mid,
    output logic [HI_W-1:0]  a_hi,
    output logic [LO_W-1:0]  rd_data
);
    req_t    req_in, req_q;
    tstate_e state;
    logic    ph, capture;
    logic [2:0] status;

    always_comb begin
        req_in.kind  = kind_e'(req_kind);
        req_in.addr  = req_addr;
        req_in.seg   = req_seg;
        req_in.wdata = req_wdata;
    end

    mbs_fsm u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_in.kind),
        .ready(ready), .state(state), .ph(ph), .accept(req_accept),
        .done(cyc_done), .capture(capture)
    );

    mbs_hold u_hold (
        .clk(clk), .rst(rst), .accept(req_accept), .req_in(req_in),
        .capture(capture), .ad_in(ad_in), .req_q(req_q), .rd_data(rd_data)
    );

    mbs_pins u_pins (
        .state(state), .ph(ph), .req_q(req_q), .ie_flag(ie_flag),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .den_n(den_n),
        .status(status), .ad_out(ad_out), .ad_oe(ad_oe), .a_mid(a_mid), .a_hi(a_hi)
    );

    assign {io_m, dt_r, ss0} = status;

    p_ale_status_r7: assert property (@(posedge clk) disable iff (rst)
        ale |-> ({io_m, dt_r, ss0} != 3'b011));
    p_done_after_ale_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |-> !cyc_done);
endmodule

// File: tb/mux_bus_sequencer_bench.sv
module mux_bus_sequencer_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [2:0] req_kind = 3'b011;
    logic [19:0] req_addr = '0;
    logic [1:0] req_seg = '0;
    logic [7:0] req_wdata = '0;
    logic ie_flag = 1'b0;
    logic ready = 1'b1;
    logic [7:0] ad_in = '0;
    logic req_accept, cyc_done, ale, rd_n, wr_n, inta_n, den_n, io_m, dt_r, ss0, ad_oe;
    logic [7:0] ad_out, a_mid, rd_data;
    logic [3:0] a_hi;

    always #10 clk = ~clk;

    mux_bus_sequencer u_mux_bus_sequencer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_seg(req_seg), .req_wdata(req_wdata),
        .ie_flag(ie_flag), .ready(ready), .ad_in(ad_in),
        .req_accept(req_accept), .cyc_done(cyc_done), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .inta_n(inta_n), .den_n(den_n), .io_m(io_m), .dt_r(dt_r),
        .ss0(ss0), .ad_out(ad_out), .ad_oe(ad_oe), .a_mid(a_mid), .a_hi(a_hi),
        .rd_data(rd_data)
    );

    typedef struct packed {
        logic acc, done, ale, rd_n, wr_n, inta_n, den_n;
        logic [2:0] st;
        logic oe;
        logic [7:0] ad;
        logic [3:0] hi;
        logic [7:0] mid;
        logic rchk;
        logic [7:0] rdv;
        logic [1:0] tg;   // 1: wait tick, 2: chaining tick
    } exp_t;

    typedef struct {
        logic [2:0] k;
        logic [19:0] a;
        logic [1:0] s;
        logic [7:0] wd;
        logic [7:0] rdv;
        int waits;
        logic ie;
    } op_t;

    exp_t expq[$];
    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] last_mid = 8'h00;
    bit finished = 0;

    task automatic cmp(string r, string f, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s t=%0t actual %0h expected %0h", r, f, $time, act, exp);
        end
    endtask

    function automatic exp_t idle_exp(logic acc);
        exp_t e;
        e = '0;
        e.acc = acc; e.rd_n = 1; e.wr_n = 1; e.inta_n = 1; e.den_n = 1;
        e.st = 3'b011; e.hi = 4'h0; e.mid = last_mid;
        return e;
    endfunction

    function automatic exp_t cyc_exp(op_t o, int s, logic ph, logic acc, logic [1:0] tg);
        exp_t e;
        logic rdt, wrt, ack, mid;
        rdt = (o.k == 3'b000) || (o.k == 3'b001) || (o.k == 3'b101);
        wrt = (o.k == 3'b010) || (o.k == 3'b110);
        ack = (o.k == 3'b100);
        mid = (s == 2) || (s == 3) || (s == 4);
        e = '0;
        e.acc = acc; e.done = (s == 5) && ph; e.ale = (s == 1);
        e.rd_n = !(rdt && mid); e.wr_n = !(wrt && mid); e.inta_n = !(ack && mid);
        if (wrt) e.den_n = !(mid || (s == 5 && !ph));
        else if (rdt || ack) e.den_n = !((s == 2 && ph) || s == 3 || s == 4 || (s == 5 && !ph));
        else e.den_n = 1'b1;
        e.st = o.k;
        e.oe = (s == 1) || (wrt && s >= 2);
        e.ad = (s == 1) ? o.a[7:0] : o.wd;
        e.hi = (s == 1) ? (o.k[2] ? 4'h0 : o.a[19:16]) : {1'b0, o.ie, o.s};
        e.mid = o.a[15:8];
        e.rchk = (rdt || ack) && (s == 5);
        e.rdv = o.rdv;
        e.tg = tg;
        return e;
    endfunction

    // scoreboard monitor: one expected item per tick, compared mid-tick
    always @(negedge clk) begin
        if (!rst && expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            cmp(e.tg == 2 ? "R11" : "R2", "req_accept", 32'(req_accept), 32'(e.acc));
            cmp(e.tg == 2 ? "R11" : "R3", "cyc_done", 32'(cyc_done), 32'(e.done));
            cmp("R3", "ale", 32'(ale), 32'(e.ale));
            cmp(e.tg == 1 ? "R4" : "R5", "strobes", 32'({rd_n, wr_n, inta_n}),
                32'({e.rd_n, e.wr_n, e.inta_n}));
            cmp("R6", "den_n", 32'(den_n), 32'(e.den_n));
            cmp("R7", "status", 32'({io_m, dt_r, ss0}), 32'(e.st));
            cmp("R8", "a_hi", 32'(a_hi), 32'(e.hi));
            cmp("R9", "a_mid", 32'(a_mid), 32'(e.mid));
            cmp("R10", "ad_oe", 32'(ad_oe), 32'(e.oe));
            if (e.oe) cmp("R10", "ad_out", 32'(ad_out), 32'(e.ad));
            if (e.rchk) cmp("R10", "rd_data", 32'(rd_data), 32'(e.rdv));
        end
    end

    task automatic go_edge;
        @(posedge clk);
        #1;
    endtask

    task automatic present(op_t o);
        req_valid = 1'b1; req_kind = o.k; req_addr = o.a;
        req_seg = o.s; req_wdata = o.wd;
    endtask

    task automatic idle_ticks(int n);
        for (int i = 0; i < n; i++) begin
            go_edge;
            req_valid = 1'b0;
            expq.push_back(idle_exp(1'b0));
        end
    endtask

    task automatic bus_op(op_t o, bit chained, bit has_next, op_t nx, bit poke);
        op_t pk;
        if (!chained) begin
            go_edge;
            present(o);
            expq.push_back(idle_exp(o.k != 3'b011));
            if (o.k == 3'b011) return;   // R2: ignored kind
        end
        go_edge; req_valid = 1'b0; ie_flag = o.ie; ad_in = o.rdv; ready = 1'b1;
        expq.push_back(cyc_exp(o, 1, 1'b0, 1'b0, 2'd0));
        go_edge; expq.push_back(cyc_exp(o, 1, 1'b1, 1'b0, 2'd0));
        last_mid = o.a[15:8];
        go_edge;
        if (poke) begin          // R2: request mid-cycle must be ignored
            pk = o; pk.k = 3'b001; pk.a = 20'h0FFFF; pk.wd = 8'hEE;
            present(pk);
        end
        expq.push_back(cyc_exp(o, 2, 1'b0, 1'b0, 2'd0));
        go_edge; req_valid = 1'b0; expq.push_back(cyc_exp(o, 2, 1'b1, 1'b0, 2'd0));
        go_edge; expq.push_back(cyc_exp(o, 3, 1'b0, 1'b0, 2'd0));
        go_edge; ready = (o.waits == 0); expq.push_back(cyc_exp(o, 3, 1'b1, 1'b0, 2'd0));
        for (int i = 0; i < o.waits; i++) begin   // R4 wait states
            go_edge; ready = 1'b1; expq.push_back(cyc_exp(o, 4, 1'b0, 1'b0, 2'd1));
            go_edge; ready = (i == o.waits - 1); expq.push_back(cyc_exp(o, 4, 1'b1, 1'b0, 2'd1));
        end
        go_edge; ready = 1'b1; expq.push_back(cyc_exp(o, 5, 1'b0, 1'b0, 2'd0));
        go_edge;
        if (has_next) present(nx);     // R11 chaining
        expq.push_back(cyc_exp(o, 5, 1'b1, has_next, has_next ? 2'd2 : 2'd0));
    endtask

    function automatic op_t mk(logic [2:0] k, logic [19:0] a, logic [1:0] s,
                               logic [7:0] wd, logic [7:0] rdv, int w, logic ie);
        op_t o;
        o.k = k; o.a = a; o.s = s; o.wd = wd; o.rdv = rdv; o.waits = w; o.ie = ie;
        return o;
    endfunction

    initial begin
        op_t a, b, c, d, none;
        none = mk(3'b011, 20'h0, 2'b00, 8'h0, 8'h0, 0, 1'b0);
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        cmp("R1", "ale", 32'(ale), 32'd0);
        cmp("R1", "strobes", 32'({rd_n, wr_n, inta_n, den_n}), 32'hF);
        cmp("R1", "status", 32'({io_m, dt_r, ss0}), 32'd3);
        cmp("R1", "done/accept", 32'({cyc_done, req_accept}), 32'd0);
        cmp("R1", "a_hi/ad_oe", 32'({a_hi, ad_oe}), 32'd0);
        idle_ticks(2);
        // memory read, no waits, data segment
        a = mk(3'b001, 20'hA5C3E, 2'b11, 8'h00, 8'h5A, 0, 1'b1);
        bus_op(a, 0, 0, none, 0);
        idle_ticks(1);
        // memory write with two waits, stack segment
        a = mk(3'b010, 20'h3B7C1, 2'b01, 8'hC4, 8'h00, 2, 1'b0);
        bus_op(a, 0, 0, none, 0);
        // I/O read, one wait: upper lines blank in T1
        a = mk(3'b101, 20'hF00AB, 2'b10, 8'h00, 8'h99, 1, 1'b1);
        bus_op(a, 0, 0, none, 0);
        idle_ticks(2);
        // chain: I/O write -> code fetch -> acknowledge with three waits
        b = mk(3'b110, 20'h70355, 2'b00, 8'h3D, 8'h00, 0, 1'b0);
        c = mk(3'b000, 20'hFFFF0, 2'b10, 8'h00, 8'hEA, 0, 1'b1);
        d = mk(3'b100, 20'h12345, 2'b10, 8'h00, 8'h21, 3, 1'b0);
        bus_op(b, 0, 1, c, 0);
        bus_op(c, 1, 1, d, 0);
        bus_op(d, 1, 0, none, 0);
        // passive kind ignored
        bus_op(none, 0, 0, none, 0);
        idle_ticks(2);
        // halt with a request poked in T2 that must be ignored
        a = mk(3'b111, 20'h6A1F2, 2'b00, 8'h00, 8'h77, 0, 1'b1);
        bus_op(a, 0, 0, none, 1);
        idle_ticks(2);
        // long wait read
        a = mk(3'b001, 20'h4E2D9, 2'b00, 8'h00, 8'hB3, 5, 1'b0);
        bus_op(a, 0, 0, none, 0);
        idle_ticks(3);
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule